// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block takes a DDR SDRAM device from power-on to a state where reads are allowed. It watches a power-stable input and then holds the clock enable low for a programmable settle time. It raises the clock enable and walks a fixed list of commands. Between commands it inserts the device's minimum spacing, counted in clock cycles by a shared loadable down-counter. Each command is a single-cycle strobe on the chip-select, row-strobe, column-strobe and write-enable pins. Every other cycle carries a NOP.

The command order is: precharge-all, extended mode write, mode write with the DLL-reset bit set, a second precharge-all, a programmable number of auto-refresh commands, and a final mode write with the DLL-reset bit cleared. A separate lock timer starts on the DLL-reset mode write. The ready flag is raised only when that timer has expired and the last mode write's spacing has elapsed.

The FSM states are named as follows:

- **Power-up:** IDLE, PWR_WAIT and CKE_RISE.
- **Commands:** PRE1, EMRS, MRS_DLL, PRE2, AREF and MRS_OP, each followed by its own *_GAP state.
- **Finish:** LOCK_WAIT and READY.

The transitions are as follows:

- IDLE goes to PWR_WAIT when power is stable.
- PWR_WAIT goes back to IDLE if power drops, or to CKE_RISE when the settle count ends.
- Each command state goes to its gap state.
- Each gap state goes to the next command state when its count ends.
- AREF_GAP returns to AREF until the refresh count is reached.
- MRS_OP_GAP goes to LOCK_WAIT.
- LOCK_WAIT goes to READY once the lock timer is done.
- READY holds until reset.

Top module: `ddr_powerup_sequencer`

## Requirements
- R1: While rst_n is low, cke and init_done are 0, the command pins {cs_n,ras_n,cas_n,we_n} show NOP (4'b0111), and addr and ba are all zero.
- R2: While pwr_stable stays low after reset, cke stays 0 and no non-NOP command appears.
- R3: The power-stable settle window works as follows:
  - Once pwr_stable is seen high, the bus carries NOP with cke low for exactly T_PWR cycles.
  - cke rises in the next cycle, and the first command follows one cycle after cke rises.
  - If pwr_stable falls during the settle window, the block returns to idle and later restarts the full window.
- R4: The command order is PRE, EMRS, MRS(DLL reset), PRE, N_REF times AREF, then MRS(operate). The pin codes are PRE = 4'b0010, AREF = 4'b0001, and both mode writes = 4'b0000.
- R5: A precharge-all drives addr with only bit 10 set and ba = 2'b00. The next command comes exactly T_RP cycles later.
- R6: EMRS drives ba = 2'b01 and addr = emr_code. Both MRS commands drive ba = 2'b00. Each mode write is followed by exactly T_MRD cycles before the next command.
- R7: The DLL-reset MRS drives mr_code with bit 8 forced to 1. The final MRS drives mr_code with bit 8 forced to 0. All other bits come from mr_code.
- R8: Each AREF drives addr = 0 and ba = 2'b00, and is followed by exactly T_RFC cycles before the next command.
- R9: Every command lasts one cycle with NOP between commands. No command is issued while cke is low. Once raised, cke stays high until reset.
- R10: init_done rises in the first cycle in which both of these hold:
  - T_LOCK cycles have passed since the DLL-reset MRS.
  - The final MRS spacing has ended.

  With the bench parameters this is exactly T_LOCK+1 cycles after the DLL-reset MRS. init_done then stays high with only NOPs until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_stable | input | 1 | Supplies and clock are stable |
| emr_code | input | ADDR_W | Extended mode register value |
| mr_code | input | ADDR_W | Base mode register value (bit 8 overridden) |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus |
| ba | output | 2 | Bank address |
| init_done | output | 1 | Initialization complete, reads allowed |

## Verification
The assertions check the following on every cycle:

- No command is issued without cke high in this and the previous cycle.
- A command is never followed directly by another.
- A precharge always has bit 10 set.
- The DLL-reset write carries bit 8 high.
- init_done is sticky and never high before the lock timer has expired.

Only the bench scenarios can show the exact spacing between commands, the full command order with the mode codes passed through, and the cke rise time relative to pwr_stable. The same applies to the restart after pwr_stable drops mid-window and the exact cycle in which init_done rises.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    // Pin order {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP  = 4'b0111,
        CMD_PRE  = 4'b0010,
        CMD_AREF = 4'b0001,
        CMD_MODE = 4'b0000
    } ddr_cmd_e;

    typedef enum logic [2:0] {
        ADR_ZERO,
        ADR_PRE_ALL,
        ADR_EXT,
        ADR_MODE_DLL,
        ADR_MODE_OP
    } adr_sel_e;

    typedef enum logic [4:0] {
        S_IDLE,
        S_PWR_WAIT,
        S_CKE_RISE,
        S_PRE1,
        S_PRE1_GAP,
        S_EMRS,
        S_EMRS_GAP,
        S_MRS_DLL,
        S_MRS_DLL_GAP,
        S_PRE2,
        S_PRE2_GAP,
        S_AREF,
        S_AREF_GAP,
        S_MRS_OP,
        S_MRS_OP_GAP,
        S_LOCK_WAIT,
        S_READY
    } init_state_e;

    localparam int PRE_ALL_BIT = 10;
    localparam int DLL_RST_BIT = 8;
    localparam logic [1:0] BANK_EXT  = 2'b01;
    localparam logic [1:0] BANK_BASE = 2'b00;

endpackage

// File: rtl/ddr_gap_timer.sv
module ddr_gap_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == CNT_W'(1));

    // A load must land in the counter on the next edge (R5 spacing basis)
    p_gap_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(load_val));

endmodule

// File: rtl/ddr_lock_timer.sv
module ddr_lock_timer #(
    parameter int T_LOCK = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);

    localparam int LCW = $clog2(T_LOCK + 1);

    logic [LCW-1:0] cnt_q;
    logic           armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (start) begin
            cnt_q   <= LCW'(T_LOCK - 1);
            armed_q <= 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = armed_q && (cnt_q == '0);

    p_lock_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

endmodule

// File: rtl/ddr_cmd_encoder.sv
module ddr_cmd_encoder
    import ddr_init_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  ddr_cmd_e          cmd,
    input  adr_sel_e          adr_sel,
    input  logic [ADDR_W-1:0] emr_code,
    input  logic [ADDR_W-1:0] mr_code,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [1:0]        ba
);

    assign {cs_n, ras_n, cas_n, we_n} = cmd;

    always_comb begin
        addr = '0;
        ba   = BANK_BASE;
        unique case (adr_sel)
            ADR_ZERO: begin
                addr = '0;
            end
            ADR_PRE_ALL: begin
                addr[PRE_ALL_BIT] = 1'b1;
            end
            ADR_EXT: begin
                addr = emr_code;
                ba   = BANK_EXT;
            end
            ADR_MODE_DLL: begin
                addr              = mr_code;
                addr[DLL_RST_BIT] = 1'b1;
            end
            ADR_MODE_OP: begin
                addr              = mr_code;
                addr[DLL_RST_BIT] = 1'b0;
            end
            default: begin
                addr = '0;
            end
        endcase
    end

endmodule

// File: rtl/ddr_powerup_sequencer.sv
module ddr_powerup_sequencer
    import ddr_init_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int T_PWR  = 50000,
    parameter int T_RP   = 4,
    parameter int T_MRD  = 2,
    parameter int T_RFC  = 18,
    parameter int N_REF  = 2,
    parameter int T_LOCK = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_stable,
    input  logic [ADDR_W-1:0] emr_code,
    input  logic [ADDR_W-1:0] mr_code,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [1:0]        ba,
    output logic              init_done
);

    localparam int TMAX_A = (T_PWR > T_RFC) ? T_PWR : T_RFC;
    localparam int TMAX_B = (T_RP > T_MRD) ? T_RP : T_MRD;
    localparam int TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
    localparam int CW     = $clog2(TMAX + 1);
    localparam int RW     = $clog2(N_REF + 1);

    init_state_e     state_q, state_d;
    logic            tmr_load;
    logic [CW-1:0]   tmr_val;
    logic            tmr_last;
    logic            lock_done;
    logic [RW-1:0]   ref_cnt_q;
    ddr_cmd_e        cmd;
    adr_sel_e        adr_sel;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Refresh counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_cnt_q <= '0;
        end else if (state_q == S_AREF) begin
            ref_cnt_q <= ref_cnt_q + 1'b1;
        end
    end

    // Next state and interval loading
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            S_IDLE: begin
                if (pwr_stable) begin
                    state_d  = S_PWR_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(T_PWR);
                end
            end
            S_PWR_WAIT: begin
                if (!pwr_stable) begin
                    state_d = S_IDLE;
                end else if (tmr_last) begin
                    state_d = S_CKE_RISE;
                end
            end
            S_CKE_RISE: state_d = S_PRE1;
            S_PRE1: begin
                state_d  = S_PRE1_GAP;
                tmr_load = 1'b1;
                tmr_val  = CW'(T_RP - 1);
            end
            S_PRE1_GAP: if (tmr_last) state_d = S_EMRS;
            S_EMRS: begin
                state_d  = S_EMRS_GAP;
                tmr_load = 1'b1;
                tmr_val  = CW'(T_MRD - 1);
            end
            S_EMRS_GAP: if (tmr_last) state_d = S_MRS_DLL;
            S_MRS_DLL: begin
                state_d  = S_MRS_DLL_GAP;
                tmr_load = 1'b1;
                tmr_val  = CW'(T_MRD - 1);
            end
            S_MRS_DLL_GAP: if (tmr_last) state_d = S_PRE2;
            S_PRE2: begin
                state_d  = S_PRE2_GAP;
                tmr_load = 1'b1;
                tmr_val  = CW'(T_RP - 1);
            end
            S_PRE2_GAP: if (tmr_last) state_d = S_AREF;
            S_AREF: begin
                state_d  = S_AREF_GAP;
                tmr_load = 1'b1;
                tmr_val  = CW'(T_RFC - 1);
            end
            S_AREF_GAP: begin
                if (tmr_last) begin
                    state_d = (ref_cnt_q == RW'(N_REF)) ? S_MRS_OP : S_AREF;
                end
            end
            S_MRS_OP: begin
                state_d  = S_MRS_OP_GAP;
                tmr_load = 1'b1;
                tmr_val  = CW'(T_MRD - 1);
            end
            S_MRS_OP_GAP: if (tmr_last) state_d = S_LOCK_WAIT;
            S_LOCK_WAIT: if (lock_done) state_d = S_READY;
            S_READY: state_d = S_READY;
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cmd       = CMD_NOP;
        adr_sel   = ADR_ZERO;
        cke       = 1'b1;
        init_done = 1'b0;
        unique case (state_q)
            S_IDLE, S_PWR_WAIT: cke = 1'b0;
            S_PRE1, S_PRE2: begin
                cmd     = CMD_PRE;
                adr_sel = ADR_PRE_ALL;
            end
            S_EMRS: begin
                cmd     = CMD_MODE;
                adr_sel = ADR_EXT;
            end
            S_MRS_DLL: begin
                cmd     = CMD_MODE;
                adr_sel = ADR_MODE_DLL;
            end
            S_MRS_OP: begin
                cmd     = CMD_MODE;
                adr_sel = ADR_MODE_OP;
            end
            S_AREF: cmd = CMD_AREF;
            S_READY: init_done = 1'b1;
            default: cmd = CMD_NOP;
        endcase
    end

    ddr_gap_timer #(.CNT_W(CW)) gap_tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    ddr_lock_timer #(.T_LOCK(T_LOCK)) lock_tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (state_q == S_MRS_DLL),
        .done  (lock_done)
    );

    ddr_cmd_encoder #(.ADDR_W(ADDR_W)) enc_i (
        .cmd      (cmd),
        .adr_sel  (adr_sel),
        .emr_code (emr_code),
        .mr_code  (mr_code),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .addr     (addr),
        .ba       (ba)
    );

    logic cmd_on_bus;
    assign cmd_on_bus = !cs_n && !(ras_n && cas_n && we_n);

    p_cmd_needs_cke_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_on_bus |-> (cke && $past(cke)));

    p_single_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_on_bus |=> !cmd_on_bus);

    p_idle_cke_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_stable && !cke) |=> !cke);

    p_pre_all_a10_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ({cs_n, ras_n, cas_n, we_n} == 4'b0010) |-> (addr[PRE_ALL_BIT] && ba == 2'b00));

    p_dll_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_MRS_DLL) |-> addr[DLL_RST_BIT]);

    p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    p_done_needs_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> lock_done);

endmodule

// File: tb/ddr_powerup_sequencer_tb_top.sv
`timescale 1ns/1ps
module ddr_powerup_sequencer_tb_top;

    localparam int ADDR_W = 13;
    localparam int T_PWR  = 40;
    localparam int T_RP   = 3;
    localparam int T_MRD  = 2;
    localparam int T_RFC  = 8;
    localparam int N_REF  = 2;
    localparam int T_LOCK = 200;
    localparam int NV     = 7;

    // Expected command table: pin code, kind, spacing from previous event
    // kind: 0 precharge, 1 ext mode, 2 mode dll, 3 mode op, 4 refresh
    localparam logic [3:0] EXP_CMD [NV] = '{4'b0010, 4'b0000, 4'b0000, 4'b0010,
                                            4'b0001, 4'b0001, 4'b0000};
    localparam int EXP_KIND [NV] = '{0, 1, 2, 0, 4, 4, 3};
    localparam int EXP_GAP  [NV] = '{T_PWR + 2, T_RP, T_MRD, T_MRD, T_RP, T_RFC, T_RFC};

    logic              clk = 1'b0;
    logic              rst_n;
    logic              pwr_stable;
    logic [ADDR_W-1:0] emr_code;
    logic [ADDR_W-1:0] mr_code;
    logic              cke, cs_n, ras_n, cas_n, we_n, init_done;
    logic [ADDR_W-1:0] addr;
    logic [1:0]        ba;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    int               n_log;
    logic [3:0]       log_cmd  [16];
    int               log_cyc  [16];
    logic [ADDR_W-1:0] log_addr [16];
    logic [1:0]       log_ba   [16];
    int               cke_cyc, done_cyc, cke_drop, b2b;
    logic             prev_cmd;

    always #2 clk = ~clk;
    always @(posedge clk) cyc++;

    ddr_powerup_sequencer #(
        .ADDR_W(ADDR_W), .T_PWR(T_PWR), .T_RP(T_RP), .T_MRD(T_MRD),
        .T_RFC(T_RFC), .N_REF(N_REF), .T_LOCK(T_LOCK)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_stable(pwr_stable),
        .emr_code(emr_code), .mr_code(mr_code), .cke(cke),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .ba(ba), .init_done(init_done)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if ({cs_n, ras_n, cas_n, we_n} != 4'b0111) begin
                if (n_log < 16) begin
                    log_cmd[n_log]  = {cs_n, ras_n, cas_n, we_n};
                    log_cyc[n_log]  = cyc;
                    log_addr[n_log] = addr;
                    log_ba[n_log]   = ba;
                end
                n_log++;
                if (prev_cmd) b2b++;
                prev_cmd = 1'b1;
            end else begin
                prev_cmd = 1'b0;
            end
            if (cke && cke_cyc < 0) cke_cyc = cyc;
            if (!cke && cke_cyc >= 0) cke_drop++;
            if (init_done && done_cyc < 0) done_cyc = cyc;
        end
    end

    task automatic clear_logs();
        n_log = 0; cke_cyc = -1; done_cyc = -1; cke_drop = 0; b2b = 0; prev_cmd = 1'b0;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] exp_addr(input int kind,
            input logic [ADDR_W-1:0] e, input logic [ADDR_W-1:0] m);
        logic [ADDR_W-1:0] r;
        r = '0;
        case (kind)
            0: r[10] = 1'b1;
            1: r = e;
            2: begin r = m; r[8] = 1'b1; end
            3: begin r = m; r[8] = 1'b0; end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string kind_tag(input int kind);
        case (kind)
            0: return "R5 precharge";
            1: return "R6 ext mode";
            2: return "R7 mode dll";
            3: return "R7 mode op";
            default: return "R8 refresh";
        endcase
    endfunction

    task automatic check_reset_state();
        chk("R1 cke", int'(cke), 0);
        chk("R1 pins", int'({cs_n, ras_n, cas_n, we_n}), 7);
        chk("R1 addr", int'(addr), 0);
        chk("R1 ba", int'(ba), 0);
        chk("R1 init_done", int'(init_done), 0);
    endtask

    task automatic run_and_check(input logic [ADDR_W-1:0] e, input logic [ADDR_W-1:0] m);
        int a;
        int prev;
        emr_code = e;
        mr_code  = m;
        @(posedge clk); #1;
        pwr_stable = 1'b1;
        a = cyc;
        repeat (T_PWR + T_LOCK + 80) @(posedge clk);
        #1;
        chk("R3 cke rise cycle", cke_cyc - a, T_PWR + 1);
        chk("R4 command count", n_log, NV);
        for (int i = 0; i < NV; i++) begin
            prev = (i == 0) ? a : log_cyc[i];
            if (i > 0) prev = log_cyc[i-1];
            chk({"R4 order ", kind_tag(EXP_KIND[i])}, int'(log_cmd[i]), int'(EXP_CMD[i]));
            chk({kind_tag(EXP_KIND[i]), " bank"}, int'(log_ba[i]),
                (EXP_KIND[i] == 1) ? 1 : 0);
            chk({kind_tag(EXP_KIND[i]), " addr"}, int'(log_addr[i]),
                int'(exp_addr(EXP_KIND[i], e, m)));
            chk({(i == 0) ? "R3 first command" : kind_tag(EXP_KIND[i-1]), " spacing"},
                log_cyc[i] - prev, EXP_GAP[i]);
        end
        chk("R10 init_done rise", done_cyc - log_cyc[2], T_LOCK + 1);
        chk("R9 cke drop", cke_drop, 0);
        chk("R9 back-to-back commands", b2b, 0);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pwr_stable = 1'b0;
        emr_code = '0; mr_code = '0;
        clear_logs();
        repeat (3) @(posedge clk);
        #1;
        check_reset_state();
        rst_n = 1'b1;
        repeat (50) @(posedge clk);
        #1;
        chk("R2 no command while unpowered", n_log, 0);
        chk("R2 cke low while unpowered", cke_cyc, -1);

        // First run: mr bit 8 low, must be forced high on DLL reset
        run_and_check(13'h0A21, 13'h0032);

        // Reset after ready
        @(posedge clk); #1;
        rst_n = 1'b0; pwr_stable = 1'b0;
        #1;
        check_reset_state();
        repeat (2) @(posedge clk);
        #1;
        clear_logs();
        rst_n = 1'b1;

        // Abort of settle window
        @(posedge clk); #1;
        pwr_stable = 1'b1;
        repeat (10) @(posedge clk);
        #1;
        pwr_stable = 1'b0;
        repeat (T_PWR + 20) @(posedge clk);
        #1;
        chk("R3 abort no command", n_log, 0);
        chk("R3 abort cke low", cke_cyc, -1);

        // Second run: mr bit 8 high, must be forced low on final MRS
        run_and_check(13'h0ABC, 13'h0163);
        repeat (50) @(posedge clk);
        #1;
        chk("R10 init_done sticky", int'(init_done), 1);
        chk("R10 only NOP after ready", n_log, NV);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule